// File: doc/BRIEF.md
# Bit-Serial SHA-256 Message Schedule Generator

This block expands one 512-bit message block into the 64-word SHA-256 message schedule. Every word travels on a one-bit wire, least significant bit first, one bit per clock. A word therefore occupies 32 consecutive clocks, and a whole block takes 2048 clocks. The sixteen message words enter on a serial input. They are copied to the serial output unchanged and are also recorded in a 512-bit history delay line. The remaining 48 words are then computed from that history and fed back into it.

Each schedule word is formed as sigma1(W[t-2]) + W[t-7] + sigma0(W[t-15]) + W[t-16], modulo 2^32. The rotations and shifts are not wired across a 32-bit word. Each operand bit is taken from a fixed tap on the history line, and the distance of the tap from the line's input selects the rotation amount. The additions use a tree of three one-bit adders. Each adder keeps one flip-flop for its sum bit and one for its carry, and the carry is cleared at the first bit of every word. All sums are plain binary before any bit of them is rotated or XOR-ed again.

A block starts when the word-start strobe and the load qualifier are high together while the block is idle. After that the block follows its own bit and word counters until the 64th word has been sent. A new block may start on the very next clock.

Top module: `sha_sched_serial`

## Requirements
- R1: A clock with inStart=1 and inLoad=1 while the block is idle starts a block. One clock later, outStart=1 and outBit carries bit 0 of word 0.
- R2: A block's output is 64 contiguous words of 32 clocks each, least significant bit first. outStart is 1 exactly on the clock that carries bit 0 of each word.
- R3: For words 0 to 15, outBit equals the inBit sampled one clock earlier, so the message words pass through unchanged.
- R4: Words 16 to 63 equal ror17(x)^ror19(x)^shr10(x) with x=W[t-2], plus W[t-7], plus ror7(y)^ror18(y)^shr3(y) with y=W[t-15], plus W[t-16]. Here rorN(v) bit i is v bit (i+N) mod 32, and shrN(v) bit i is v bit i+N, or 0 when i+N>31.
- R5: Every sum is taken modulo 2^32, and no carry crosses from one word into the next. This holds even when all message words are 0xFFFFFFFF.
- R6: Once a block has started, inStart, inLoad, and inBit outside words 0 to 15 have no effect on the output stream.
- R7: inStart=1 with inLoad=0 while idle does not start a block. outStart and outBit stay 0.
- R8: After reset, and whenever no block is running, outBit=0 and outStart=0.
- R9: A new block may start on the clock right after the last bit of the previous block. The two output streams then follow each other with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inBit | input | 1 | Serial message bit, least significant bit first |
| inStart | input | 1 | Marks bit 0 of an input word; starts a block together with inLoad |
| inLoad | input | 1 | High while message words are presented |
| outBit | output | 1 | Serial schedule bit, least significant bit first |
| outStart | output | 1 | High on bit 0 of each output word |

## Verification
Every output bit is due exactly one clock after the input cycle it belongs to. For words 0 to 15 that input cycle is the clock that carried the message bit. For later words it is the slot in the block's 2048-clock frame that bit occupies. The bench drives inputs at the falling edge and records the expected bit and marker for that clock. At the next falling edge it compares them with the outputs, so each output clock is checked against a behavioural schedule model. The adder tree's internal two-clock lead is hidden behind the history taps, so the bench never needs to know about it.

// File: rtl/sha_sched_pkg.sv
`timescale 1ns/1ps
package sha_sched_pkg;
  localparam int WORD_BITS = 32;
  localparam int BIT_CNT_W = $clog2(WORD_BITS);
  // clocks from history taps to the stream: two registered adder levels
  localparam int ADD_LAT   = 2;

  // word ages of the four operands
  localparam int AGE_S1 = 2;
  localparam int AGE_P1 = 7;
  localparam int AGE_S0 = 15;
  localparam int AGE_P2 = 16;

  // small sigma on the older operand
  localparam int S0_ROT_A = 7;
  localparam int S0_ROT_B = 18;
  localparam int S0_SHR   = 3;
  // small sigma on the newer operand
  localparam int S1_ROT_A = 17;
  localparam int S1_ROT_B = 19;
  localparam int S1_SHR   = 10;

  typedef struct packed {
    logic                 active;     // stream slot belongs to a block
    logic                 load;       // slot is in the pass-through words
    logic                 wordStart;  // slot carries bit 0 of a word
    logic                 firstA;     // first-level adders see operand bit 0
    logic                 firstC;     // final adder sees operand bit 0
    logic [BIT_CNT_W-1:0] tgtBit;     // bit index the taps are aimed at
  } ctrl_t;
endpackage

// File: rtl/serial_add.sv
`timescale 1ns/1ps
module serial_add (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic a,
  input  logic b,
  output logic sumQ
);
  logic carryQ;
  logic cin;

  assign cin = clr ? 1'b0 : carryQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumQ   <= 1'b0;
      carryQ <= 1'b0;
    end else begin
      sumQ   <= a ^ b ^ cin;
      carryQ <= (a & b) | (a & cin) | (b & cin);
    end
  end
endmodule

// File: rtl/sha_sched_ctrl.sv
`timescale 1ns/1ps
module sha_sched_ctrl
  import sha_sched_pkg::*;
#(
  parameter int NUM_WORDS  = 64,
  parameter int LOAD_WORDS = 16
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  inStart,
  input  logic  inLoad,
  output ctrl_t ctrl
);
  localparam int WCNT_W = $clog2(NUM_WORDS);

  logic                 busy;
  logic [BIT_CNT_W-1:0] bitCnt, curBit;
  logic [WCNT_W-1:0]    wordCnt, curWord;
  logic                 blockStart, lastBit, lastWord;
  int                   tgtSum;

  always_comb begin
    blockStart = inStart && inLoad && !busy;
    curBit     = blockStart ? '0 : bitCnt;
    curWord    = blockStart ? '0 : wordCnt;
    lastBit    = curBit == BIT_CNT_W'(WORD_BITS - 1);
    lastWord   = curWord == WCNT_W'(NUM_WORDS - 1);
    tgtSum     = int'(curBit) + ADD_LAT;
    if (tgtSum >= WORD_BITS) tgtSum = tgtSum - WORD_BITS;

    ctrl.active    = blockStart || busy;
    ctrl.load      = ctrl.active && (curWord < WCNT_W'(LOAD_WORDS));
    ctrl.wordStart = ctrl.active && (curBit == '0);
    ctrl.firstA    = curBit == BIT_CNT_W'(WORD_BITS - ADD_LAT);
    ctrl.firstC    = curBit == BIT_CNT_W'(WORD_BITS - ADD_LAT + 1);
    ctrl.tgtBit    = BIT_CNT_W'(tgtSum);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      bitCnt  <= '0;
      wordCnt <= '0;
    end else if (ctrl.active) begin
      bitCnt  <= lastBit ? '0 : curBit + 1'b1;
      wordCnt <= lastBit ? (lastWord ? '0 : curWord + 1'b1) : curWord;
      busy    <= !(lastBit && lastWord);
    end
  end
endmodule

// File: rtl/sha_sched_dp.sv
`timescale 1ns/1ps
module sha_sched_dp
  import sha_sched_pkg::*;
#(
  parameter int HIST_WORDS = 16
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  inBit,
  input  ctrl_t ctrl,
  output logic  outBit,
  output logic  outStart
);
  localparam int HIST_W     = HIST_WORDS * WORD_BITS;
  localparam int HIST_IDX_W = $clog2(HIST_W);

  logic [HIST_W-1:0] hist;   // hist[k] = stream bit from k+1 clocks ago
  logic streamBit;
  logic s1Bit, p1Bit, s0Bit, p2Bit;
  logic sumA, sumB, sumC;

  // Bit (tgt+amt) of the word 'age' words older than the one being formed.
  function automatic logic tapBit(input logic [HIST_W-1:0] h, input int age,
                                  input int amt, input logic isShift, input int tgt);
    int idx;
    if (tgt + amt < WORD_BITS) begin
      idx = age * WORD_BITS - amt - ADD_LAT - 1;
    end else if (isShift) begin
      return 1'b0;
    end else begin
      idx = age * WORD_BITS + WORD_BITS - amt - ADD_LAT - 1;
    end
    return h[HIST_IDX_W'(idx)];
  endfunction

  always_comb begin
    int tgt;
    tgt   = int'(ctrl.tgtBit);
    s1Bit = tapBit(hist, AGE_S1, S1_ROT_A, 1'b0, tgt) ^
            tapBit(hist, AGE_S1, S1_ROT_B, 1'b0, tgt) ^
            tapBit(hist, AGE_S1, S1_SHR,   1'b1, tgt);
    p1Bit = tapBit(hist, AGE_P1, 0, 1'b0, tgt);
    s0Bit = tapBit(hist, AGE_S0, S0_ROT_A, 1'b0, tgt) ^
            tapBit(hist, AGE_S0, S0_ROT_B, 1'b0, tgt) ^
            tapBit(hist, AGE_S0, S0_SHR,   1'b1, tgt);
    p2Bit = tapBit(hist, AGE_P2, 0, 1'b0, tgt);
  end

  serial_add uAddA (.clk(clk), .rstN(rstN), .clr(ctrl.firstA), .a(s1Bit), .b(p1Bit), .sumQ(sumA));
  serial_add uAddB (.clk(clk), .rstN(rstN), .clr(ctrl.firstA), .a(s0Bit), .b(p2Bit), .sumQ(sumB));
  serial_add uAddC (.clk(clk), .rstN(rstN), .clr(ctrl.firstC), .a(sumA),  .b(sumB),  .sumQ(sumC));

  assign streamBit = !ctrl.active ? 1'b0 : (ctrl.load ? inBit : sumC);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist     <= '0;
      outBit   <= 1'b0;
      outStart <= 1'b0;
    end else begin
      hist     <= {hist[HIST_W-2:0], streamBit};
      outBit   <= streamBit;
      outStart <= ctrl.wordStart;
    end
  end
endmodule

// File: rtl/sha_sched_serial.sv
`timescale 1ns/1ps
module sha_sched_serial
  import sha_sched_pkg::*;
#(
  parameter int NUM_WORDS  = 64,
  parameter int LOAD_WORDS = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic inBit,
  input  logic inStart,
  input  logic inLoad,
  output logic outBit,
  output logic outStart
);
  ctrl_t ctrl;

  sha_sched_ctrl #(.NUM_WORDS(NUM_WORDS), .LOAD_WORDS(LOAD_WORDS)) uCtrl (
    .clk(clk), .rstN(rstN), .inStart(inStart), .inLoad(inLoad), .ctrl(ctrl));

  sha_sched_dp #(.HIST_WORDS(LOAD_WORDS)) uDp (
    .clk(clk), .rstN(rstN), .inBit(inBit), .ctrl(ctrl),
    .outBit(outBit), .outStart(outStart));
endmodule

// File: rtl/sha_sched_chk.sv
`timescale 1ns/1ps
module sha_sched_chk
  import sha_sched_pkg::*;
#(
  parameter int NUM_WORDS  = 64,
  parameter int LOAD_WORDS = 16
) (
  input logic clk,
  input logic rstN,
  input logic inBit,
  input logic inStart,
  input logic inLoad,
  input logic outBit,
  input logic outStart
);
  localparam int TOTAL  = NUM_WORDS * WORD_BITS;
  localparam int LOADC  = LOAD_WORDS * WORD_BITS;
  localparam int CNT_W  = $clog2(TOTAL) + 1;

  logic [CNT_W-1:0] blkCnt;   // stream slot of the current clock, 0 when idle
  logic running, startNow;

  assign running  = blkCnt != '0;
  assign startNow = inStart && inLoad && !running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) blkCnt <= '0;
    else if (startNow) blkCnt <= CNT_W'(1);
    else if (running) blkCnt <= (blkCnt == CNT_W'(TOTAL - 1)) ? '0 : blkCnt + 1'b1;
  end

  assert_start_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    startNow |=> outStart);

  assert_word_marker_R2: assert property (@(posedge clk) disable iff (!rstN)
    outStart == (running && (blkCnt % CNT_W'(WORD_BITS)) == CNT_W'(1)));

  assert_pass_through_R3: assert property (@(posedge clk) disable iff (!rstN)
    (startNow || (running && blkCnt < CNT_W'(LOADC))) |=> outBit == $past(inBit));

  assert_no_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inStart && !inLoad && !running) |=> !outStart);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!startNow && !running) |=> (!outBit && !outStart));
endmodule

bind sha_sched_serial sha_sched_chk #(.NUM_WORDS(NUM_WORDS), .LOAD_WORDS(LOAD_WORDS)) uChk (
  .clk(clk), .rstN(rstN), .inBit(inBit), .inStart(inStart), .inLoad(inLoad),
  .outBit(outBit), .outStart(outStart));

// File: tb/tb_sha_sched_serial.sv
`timescale 1ns/1ps
module tb_sha_sched_serial;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inBit = 1'b0, inStart = 1'b0, inLoad = 1'b0;
  logic outBit, outStart;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] msg [16];
  logic [31:0] wRef [64];

  bit    pendValid = 0;
  logic  pendBit, pendStart;
  string pendTag;

  sha_sched_serial dut (.clk(clk), .rstN(rstN), .inBit(inBit), .inStart(inStart),
                        .inLoad(inLoad), .outBit(outBit), .outStart(outStart));

  always #2.5 clk = ~clk;

  function automatic logic [31:0] rotr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  task automatic buildRef();
    for (int t = 0; t < 16; t++) wRef[t] = msg[t];
    for (int t = 16; t < 64; t++) begin
      logic [31:0] a, b;
      a = rotr(wRef[t-2], 17) ^ rotr(wRef[t-2], 19) ^ (wRef[t-2] >> 10);
      b = rotr(wRef[t-15], 7) ^ rotr(wRef[t-15], 18) ^ (wRef[t-15] >> 3);
      wRef[t] = a + wRef[t-7] + b + wRef[t-16];
    end
  endtask

  // compare the previous clock's expectation, then drive this clock
  task automatic step(input logic b, input logic s, input logic l,
                      input logic eb, input logic es, input string tag);
    if (pendValid) begin
      checks++;
      if (outBit !== pendBit || outStart !== pendStart) begin
        errors++;
        $display("FAIL %s: outBit=%b outStart=%b expected outBit=%b outStart=%b",
                 pendTag, outBit, outStart, pendBit, pendStart);
      end
    end
    inBit = b; inStart = s; inLoad = l;
    pendBit = eb; pendStart = es; pendTag = tag; pendValid = 1;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input bit strobe, input bit noisyBit);
    for (int k = 0; k < n; k++)
      step(noisyBit ? 1'($urandom) : 1'b0, strobe ? 1'($urandom) : 1'b0, 1'b0,
           1'b0, 1'b0, strobe ? "R7 strobe without load" : "R8 idle");
  endtask

  task automatic runBlock(input string tag, input bit noise);
    buildRef();
    for (int t = 0; t < 64; t++) begin
      for (int i = 0; i < 32; i++) begin
        logic b, s, l;
        string tg;
        if (t < 16) begin
          b = msg[t][i]; s = (i == 0); l = 1'b1;
          tg = (t == 0 && i == 0) ? "R1 start / R2 marker" : "R3 pass-through";
        end else if (noise) begin
          b = 1'($urandom); s = ($urandom % 4) == 0; l = 1'($urandom);
          tg = tag;
        end else begin
          b = 1'b0; s = 1'b0; l = 1'b0; tg = tag;
        end
        step(b, s, l, wRef[t][i], (i == 0), tg);
      end
    end
  endtask

  task automatic randMsg();
    for (int k = 0; k < 16; k++) msg[k] = $urandom;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R8: reset state
    if (outBit !== 1'b0 || outStart !== 1'b0) begin
      errors++;
      $display("FAIL R8 reset: outBit=%b outStart=%b expected 0 0", outBit, outStart);
    end
    rstN = 1'b1;
    @(negedge clk);

    idle(10, 0, 1);                       // R8 quiet while idle, inBit toggling
    idle(40, 1, 1);                       // R7 strobes with inLoad low

    randMsg();
    runBlock("R4 schedule word", 0);       // R4 random block
    idle(5, 0, 0);

    for (int k = 0; k < 16; k++) msg[k] = 32'hFFFF_FFFF;
    runBlock("R5 modular sum, all ones", 0);
    idle(3, 0, 0);

    for (int k = 0; k < 16; k++) msg[k] = (k % 2 == 0) ? 32'h8000_0001 : 32'h7FFF_FFFF;
    runBlock("R5 word-boundary carry", 0);
    idle(2, 0, 0);

    randMsg();
    runBlock("R6 inputs ignored after load", 1);
    randMsg();
    runBlock("R9 back-to-back block", 0);  // no gap after previous block
    idle(20, 0, 1);                        // R8 after block end
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 idle");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule